// File: doc/BRIEF.md
# Oversampled serial transceiver with phase-accumulator baud generation

This block is a full-duplex asynchronous serial port for a peripheral bus. Bytes written by software enter a transmit queue. A transmit state machine sends each one as a 10-bit frame: a low start bit, eight data bits with the least significant bit first, and a high stop bit. A receive state machine watches the input line for a falling edge. It samples each bit in the middle, checks the stop bit, and places good bytes in a receive queue for software to read. Both machines advance on a 16x oversample tick. That tick is the carry out of a phase accumulator that adds a programmable increment every clock. The increment is computed as 16 × 2^NCO_WIDTH × baud / f_clk, so any baud rate can be reached without an integer divider.

Each queue drives its own interrupt. The receive interrupt watches for the receive fill reaching a programmable level. The transmit interrupt watches for the transmit fill falling to half the depth or less. Both are edge-qualified: an interrupt fires only when its condition becomes true while enabled. A condition that is already true when its enable is set stays silent. The state machines are: transmit TX_IDLE → TX_START (a byte is popped: enabled, queue not empty, clear-to-send honoured) → TX_DATA (after 16 ticks) → TX_STOP (after the eighth data bit) → TX_IDLE (after 16 ticks). Receive: RX_IDLE → RX_START (falling edge while enabled) → RX_IDLE (false start: the line is high at mid-bit) or RX_DATA (after 16 ticks) → RX_STOP (after the eighth bit) → RX_IDLE (at the mid-bit of the stop bit, pushing the byte only if the stop bit is high).

Top module: `nco_uart`

## Requirements
- R1: After reset the status register (address 4) reads 0xE: bit0 tx_full=0, bit1 tx_empty=1, bit2 tx_idle=1, bit3 rx_empty=1. uart_tx is high and both interrupts are low.
- R2: The oversample tick is the carry of the accumulator plus the increment (address 1). One bit lasts 16 ticks, so an increment of 2^(NCO_WIDTH-1) gives a 32-clock bit and 2^(NCO_WIDTH-2) gives a 64-clock bit.
- R3: Each frame is a 0 start bit, then 8 data bits LSB first, then a 1 stop bit. Queued bytes go out in write order.
- R4: Control register (address 0) bit0 enables transmit and bit1 enables receive. With bit0 clear, written bytes stay queued and uart_tx stays high. With bit1 clear, incoming frames are not received.
- R5: Control bit3 selects loopback. The transmitter output feeds the receiver internally, and uart_tx is held high.
- R6: Control bit2 enables flow control. A new frame starts only while cts_n is low.
- R7: Each queue holds 16 bytes. A write to address 5 while the transmit queue is full is dropped. A read of address 6 while the receive queue is empty changes nothing.
- R8: Writing 1 to bit0 (transmit) or bit1 (receive) of the queue register (address 2) empties that queue. These bits read back as 0.
- R9: The receive level is in bits [8:4] of address 2 (0 acts as 1; reset value 1). rx_irq rises when the receive fill reaches the level while bit1 of address 3 is set. It clears when the fill drops below the level. A fill already at the level when the enable is set raises nothing.
- R10: tx_irq rises when the transmit fill falls to 8 or less while bit0 of address 3 is set. A queue already at or below half when the enable is set raises nothing.
- R11: During the last frame the status shows tx_empty=1 and tx_idle=0. tx_idle returns to 1 only after the stop bit.
- R12: The receiver samples at the eighth tick of each bit. A frame whose stop bit reads 0 is discarded.
- R13: Each interrupt output is low whenever its enable bit in address 3 is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe (pops the receive queue at address 6) |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data for bus_addr, combinational |
| uart_rx | input | 1 | Serial input |
| uart_tx | output | 1 | Serial output |
| cts_n | input | 1 | Clear-to-send, active low |
| tx_irq | output | 1 | Transmit-level interrupt |
| rx_irq | output | 1 | Receive-level interrupt |

## Verification
The bench targets the interrupt edge rule. It enables each interrupt while its condition already holds and expects silence; a design that compared levels would fire at once and hang a driver that writes a partial burst. It watches the transmit status across the last frame, because a design that reported idle when the queue emptied would let software reset the line mid-byte. It also fills the transmit queue past its depth and drains it through loopback. It reads an empty receive queue, and sends a frame with a low stop bit. Overwriting, pointer slip or accepting a framing error would each show up as a wrong or extra byte.

// File: rtl/nco_uart_pkg.sv
package nco_uart_pkg;
    localparam int OVERSAMPLE = 16;
    localparam int OS_W       = $clog2(OVERSAMPLE);
    localparam int DATA_BITS  = 8;
    localparam int IDX_W      = $clog2(DATA_BITS);

    typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP} tx_state_t;
    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_t;

    localparam logic [2:0] ADDR_CTRL = 3'd0;
    localparam logic [2:0] ADDR_NCO  = 3'd1;
    localparam logic [2:0] ADDR_FIFO = 3'd2;
    localparam logic [2:0] ADDR_ICTL = 3'd3;
    localparam logic [2:0] ADDR_STAT = 3'd4;
    localparam logic [2:0] ADDR_TXD  = 3'd5;
    localparam logic [2:0] ADDR_RXD  = 3'd6;

    localparam int CTRL_TXEN = 0;
    localparam int CTRL_RXEN = 1;
    localparam int CTRL_FLOW = 2;
    localparam int CTRL_LOOP = 3;
    localparam int FIFO_TXRST = 0;
    localparam int FIFO_RXRST = 1;
    localparam int FIFO_LVL_LSB = 4;
endpackage

// File: rtl/nco_uart_fifo.sv
module nco_uart_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         push,
    input  logic [WIDTH-1:0]             din,
    input  logic                         pop,
    output logic [WIDTH-1:0]             dout,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH)); // R7
    AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        push && full && !pop && !flush |=> count == $past(count)); // R7
    AST_EMPTY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        pop && empty && !push && !flush |=> empty); // R7
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty); // R8
endmodule

// File: rtl/nco_uart_tx.sv
module nco_uart_tx
    import nco_uart_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       enable,
    input  logic       cts_ok,
    input  logic       fifo_empty,
    input  logic [7:0] fifo_data,
    output logic       fifo_pop,
    output logic       line,
    output logic       idle
);
    localparam logic [OS_W-1:0]  OS_LAST  = OS_W'(OVERSAMPLE-1);
    localparam logic [IDX_W-1:0] LAST_BIT = IDX_W'(DATA_BITS-1);

    tx_state_t        state, nxt;
    logic [OS_W-1:0]  os_cnt;
    logic [IDX_W-1:0] bit_idx;
    logic [7:0]       shreg;
    logic             bit_end;

    assign bit_end = tick && (os_cnt == OS_LAST);

    always_comb begin
        nxt = state;
        unique case (state)
            TX_IDLE:  if (enable && cts_ok && !fifo_empty) nxt = TX_START;
            TX_START: if (bit_end) nxt = TX_DATA;
            TX_DATA:  if (bit_end && bit_idx == LAST_BIT) nxt = TX_STOP;
            TX_STOP:  if (bit_end) nxt = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            os_cnt  <= '0;
            bit_idx <= '0;
            shreg   <= '0;
        end else begin
            if (state != nxt)  os_cnt <= '0;
            else if (tick)     os_cnt <= os_cnt + 1'b1;
            if (fifo_pop) begin
                shreg   <= fifo_data;
                bit_idx <= '0;
            end else if (state == TX_DATA && bit_end) begin
                shreg   <= shreg >> 1;
                bit_idx <= bit_idx + 1'b1;
            end
        end
    end

    always_comb begin
        fifo_pop = 1'b0;
        line     = 1'b1;
        unique case (state)
            TX_IDLE:  fifo_pop = (nxt == TX_START);
            TX_START: line = 1'b0;
            TX_DATA:  line = shreg[0];
            TX_STOP:  line = 1'b1;
        endcase
    end
    assign idle = (state == TX_IDLE);

    AST_TX_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        state == TX_STOP && !tick |=> state == TX_STOP); // R3
    AST_TX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        state == TX_IDLE && !enable |=> state == TX_IDLE); // R4
    AST_TX_CTS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        state == TX_IDLE && !cts_ok |=> state == TX_IDLE); // R6
    AST_TX_BUSY_AFTER_POP: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |=> !idle); // R11
endmodule

// File: rtl/nco_uart_rx.sv
module nco_uart_rx
    import nco_uart_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       enable,
    input  logic       line,
    output logic       push,
    output logic [7:0] data
);
    localparam logic [OS_W-1:0]  OS_LAST  = OS_W'(OVERSAMPLE-1);
    localparam logic [OS_W-1:0]  OS_MID   = OS_W'(OVERSAMPLE/2-1);
    localparam logic [IDX_W-1:0] LAST_BIT = IDX_W'(DATA_BITS-1);

    rx_state_t        state, nxt;
    logic [OS_W-1:0]  os_cnt;
    logic [IDX_W-1:0] bit_idx;
    logic             line_q;
    logic             mid, bit_end;

    assign mid     = tick && (os_cnt == OS_MID);
    assign bit_end = tick && (os_cnt == OS_LAST);

    always_comb begin
        nxt = state;
        unique case (state)
            RX_IDLE:  if (enable && line_q && !line) nxt = RX_START;
            RX_START: if (mid && line) nxt = RX_IDLE;
                      else if (bit_end) nxt = RX_DATA;
            RX_DATA:  if (bit_end && bit_idx == LAST_BIT) nxt = RX_STOP;
            RX_STOP:  if (mid) nxt = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            os_cnt  <= '0;
            bit_idx <= '0;
            data    <= '0;
            line_q  <= 1'b1;
        end else begin
            line_q <= line;
            if (state != nxt) os_cnt <= '0;
            else if (tick)    os_cnt <= os_cnt + 1'b1;
            if (state == RX_START)                bit_idx <= '0;
            else if (state == RX_DATA && bit_end) bit_idx <= bit_idx + 1'b1;
            if (state == RX_DATA && mid)          data <= {line, data[7:1]};
        end
    end

    always_comb begin
        push = 1'b0;
        unique case (state)
            RX_IDLE, RX_START, RX_DATA: push = 1'b0;
            RX_STOP: push = mid && line;
        endcase
    end

    AST_RX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        state == RX_IDLE && !enable |=> state == RX_IDLE); // R4
    AST_RX_PUSH_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> state == RX_IDLE && !push); // R12
endmodule

// File: rtl/nco_uart.sv
module nco_uart
    import nco_uart_pkg::*;
#(
    parameter int NCO_WIDTH  = 16,
    parameter int FIFO_DEPTH = 16,
    parameter int BUS_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       bus_addr,
    input  logic             bus_we,
    input  logic             bus_re,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic             uart_rx,
    output logic             uart_tx,
    input  logic             cts_n,
    output logic             tx_irq,
    output logic             rx_irq
);
    localparam int CW = $clog2(FIFO_DEPTH+1);
    localparam logic [CW-1:0] HALF = CW'(FIFO_DEPTH/2);
    localparam logic [NCO_WIDTH-1:0] NCO_HALF = NCO_WIDTH'(1) << (NCO_WIDTH-1);

    logic                 en_tx, en_rx, en_flow, en_loop, ie_tx, ie_rx;
    logic [NCO_WIDTH-1:0] nco_inc, nco_acc;
    logic [NCO_WIDTH:0]   nco_sum;
    logic                 tick;
    logic [CW-1:0]        rx_lvl, lvl_eff, tx_count, rx_count;
    logic                 wr_ctrl, wr_fifo, wr_txd, rd_rxd;
    logic                 tx_full, tx_empty, tx_idle, tx_pop, tx_line;
    logic                 rx_full, rx_empty, rx_push;
    logic [7:0]           tx_head, rx_head, rx_byte;
    logic [1:0]           rx_sync;
    logic                 tx_cond, tx_cond_q, tx_pend, rx_cond, rx_cond_q, rx_pend;

    assign wr_ctrl = bus_we && bus_addr == ADDR_CTRL;
    assign wr_fifo = bus_we && bus_addr == ADDR_FIFO;
    assign wr_txd  = bus_we && bus_addr == ADDR_TXD;
    assign rd_rxd  = bus_re && bus_addr == ADDR_RXD;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {en_loop, en_flow, en_rx, en_tx} <= '0;
            {ie_rx, ie_tx} <= '0;
            nco_inc <= '0;
            rx_lvl  <= CW'(1);
        end else if (bus_we) begin
            if (wr_ctrl) begin
                en_tx   <= bus_wdata[CTRL_TXEN];
                en_rx   <= bus_wdata[CTRL_RXEN];
                en_flow <= bus_wdata[CTRL_FLOW];
                en_loop <= bus_wdata[CTRL_LOOP];
            end
            if (bus_addr == ADDR_NCO)  nco_inc <= bus_wdata[NCO_WIDTH-1:0];
            if (wr_fifo)               rx_lvl  <= bus_wdata[FIFO_LVL_LSB +: CW];
            if (bus_addr == ADDR_ICTL) {ie_rx, ie_tx} <= bus_wdata[1:0];
        end
    end

    assign nco_sum = {1'b0, nco_acc} + {1'b0, nco_inc};
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nco_acc <= '0;
            tick    <= 1'b0;
            rx_sync <= 2'b11;
        end else begin
            nco_acc <= nco_sum[NCO_WIDTH-1:0];
            tick    <= nco_sum[NCO_WIDTH];
            rx_sync <= {rx_sync[0], en_loop ? tx_line : uart_rx};
        end
    end

    nco_uart_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(wr_fifo && bus_wdata[FIFO_TXRST]),
        .push(wr_txd), .din(bus_wdata[7:0]), .pop(tx_pop), .dout(tx_head),
        .count(tx_count), .full(tx_full), .empty(tx_empty));

    nco_uart_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(wr_fifo && bus_wdata[FIFO_RXRST]),
        .push(rx_push), .din(rx_byte), .pop(rd_rxd), .dout(rx_head),
        .count(rx_count), .full(rx_full), .empty(rx_empty));

    nco_uart_tx u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .enable(en_tx),
        .cts_ok(!en_flow || !cts_n), .fifo_empty(tx_empty), .fifo_data(tx_head),
        .fifo_pop(tx_pop), .line(tx_line), .idle(tx_idle));

    nco_uart_rx u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .enable(en_rx),
        .line(rx_sync[1]), .push(rx_push), .data(rx_byte));

    assign uart_tx = en_loop ? 1'b1 : tx_line;

    assign lvl_eff = (rx_lvl == '0) ? CW'(1) : rx_lvl;
    assign tx_cond = (tx_count <= HALF);
    assign rx_cond = (rx_count >= lvl_eff);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_cond_q <= 1'b1;
            rx_cond_q <= 1'b0;
            tx_pend   <= 1'b0;
            rx_pend   <= 1'b0;
        end else begin
            tx_cond_q <= tx_cond;
            rx_cond_q <= rx_cond;
            tx_pend   <= ie_tx && (tx_pend ? tx_cond : (tx_cond && !tx_cond_q));
            rx_pend   <= ie_rx && (rx_pend ? rx_cond : (rx_cond && !rx_cond_q));
        end
    end
    assign tx_irq = tx_pend && ie_tx;
    assign rx_irq = rx_pend && ie_rx;

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_CTRL: bus_rdata[3:0] = {en_loop, en_flow, en_rx, en_tx};
            ADDR_NCO:  bus_rdata[NCO_WIDTH-1:0] = nco_inc;
            ADDR_FIFO: bus_rdata[FIFO_LVL_LSB +: CW] = rx_lvl;
            ADDR_ICTL: bus_rdata[1:0] = {ie_rx, ie_tx};
            ADDR_STAT: bus_rdata[3:0] = {rx_empty, tx_idle, tx_empty, tx_full};
            ADDR_RXD:  bus_rdata[7:0] = rx_head;
            default:   bus_rdata = '0;
        endcase
    end

    AST_NCO_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        tick && $stable(nco_inc) && (nco_inc <= NCO_HALF) |=> !tick); // R2
    AST_RX_IRQ_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_irq) |-> $past(rx_count, 2) < lvl_eff); // R9
    AST_TX_IRQ_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_irq) |-> $past(tx_count, 2) > HALF); // R10
    AST_TX_IRQ_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |-> $past(ie_tx)); // R13
    AST_RX_IRQ_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> $past(ie_rx)); // R13
endmodule

// File: tb/nco_uart_bench.sv
module nco_uart_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  addr = '0;
    logic        we = 1'b0, re = 1'b0;
    logic [15:0] wdata = '0, rdata;
    logic        uart_rx = 1'b1, uart_tx, cts_n = 1'b0, tx_irq, rx_irq;
    int          n_tests = 0, n_fail = 0, cyc = 0, bitc = 32;
    bit          done = 1'b0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc++;

    nco_uart u_nco_uart (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_re(re),
        .bus_wdata(wdata), .bus_rdata(rdata), .uart_rx(uart_rx), .uart_tx(uart_tx),
        .cts_n(cts_n), .tx_irq(tx_irq), .rx_irq(rx_irq));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk); addr = a; wdata = d; we = 1'b1;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk); addr = a; re = 1'b1; #1 d = rdata;
        @(negedge clk); re = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic edge_wait(input logic lvl, output int at);
        int t = 0;
        while (uart_tx !== lvl && t < 3000) begin @(negedge clk); t++; end
        at = cyc;
    endtask

    task automatic ser_recv(output logic [7:0] b, output logic stop);
        int t;
        edge_wait(1'b0, t);
        idle(bitc / 2);
        for (int i = 0; i < 8; i++) begin idle(bitc); b[i] = uart_tx; end
        idle(bitc);
        stop = uart_tx;
    endtask

    task automatic ser_send(input logic [7:0] b, input logic stop);
        @(negedge clk); uart_rx = 1'b0; idle(bitc);
        for (int i = 0; i < 8; i++) begin uart_rx = b[i]; idle(bitc); end
        uart_rx = stop; idle(bitc);
        uart_rx = 1'b1; idle(bitc);
    endtask

    task automatic count_low(input int n, output int lows);
        lows = 0;
        repeat (n) begin @(negedge clk); if (uart_tx !== 1'b1) lows++; end
    endtask

    task automatic t_reset;
        logic [15:0] d;
        rd(3'd4, d);
        chk("R1 status after reset", d, 16'hE);
        chk("R1 uart_tx idle high", uart_tx, 1);
        chk("R1 irqs low", {tx_irq, rx_irq}, 0);
    endtask

    task automatic t_nco;
        logic [15:0] d;
        int a, b;
        wr(3'd1, 16'h8000); wr(3'd0, 16'h1);
        wr(3'd5, 16'h55);
        edge_wait(1'b0, a); edge_wait(1'b1, a); edge_wait(1'b0, b);
        chk("R2 bit period at half-range increment", b - a, 32);
        rd(3'd4, d);
        chk("R11 last frame: empty set, idle clear", d & 16'h6, 16'h2);
        idle(400);
        rd(3'd4, d);
        chk("R11 idle after stop bit", d & 16'h6, 16'h6);
        wr(3'd1, 16'h4000);
        wr(3'd5, 16'h55);
        edge_wait(1'b0, a); edge_wait(1'b1, a); edge_wait(1'b0, b);
        chk("R2 bit period at quarter-range increment", b - a, 64);
        idle(800);
        wr(3'd1, 16'h8000);
        idle(20);
    endtask

    task automatic t_frame;
        logic [7:0] b; logic s;
        wr(3'd5, 16'hA5); wr(3'd5, 16'h3C);
        ser_recv(b, s);
        chk("R3 first byte", b, 8'hA5);
        chk("R3 stop bit high", s, 1);
        ser_recv(b, s);
        chk("R3 second byte in order", b, 8'h3C);
        idle(200);
    endtask

    task automatic t_enable;
        logic [15:0] d; logic [7:0] b; logic s; int lows;
        wr(3'd0, 16'h0); wr(3'd5, 16'h77);
        count_low(400, lows);
        chk("R4 tx disabled keeps line high", lows, 0);
        rd(3'd4, d);
        chk("R4 byte stays queued", d[1], 0);
        wr(3'd0, 16'h1);
        ser_recv(b, s);
        chk("R4 byte sent once enabled", b, 8'h77);
        idle(200);
        ser_send(8'h12, 1'b1);
        rd(3'd4, d);
        chk("R4 rx disabled receives nothing", d[3], 1);
    endtask

    task automatic t_flow;
        logic [7:0] b; logic s; int lows;
        cts_n = 1'b1;
        wr(3'd0, 16'h5); wr(3'd5, 16'h3A);
        count_low(400, lows);
        chk("R6 held while cts_n high", lows, 0);
        cts_n = 1'b0;
        ser_recv(b, s);
        chk("R6 sent after cts_n low", b, 8'h3A);
        idle(200);
        wr(3'd0, 16'h0);
    endtask

    task automatic t_loopback;
        logic [15:0] d; int lows;
        wr(3'd0, 16'hB); wr(3'd5, 16'h96);
        count_low(500, lows);
        chk("R5 external line held high", lows, 0);
        rd(3'd6, d);
        chk("R5 looped byte received", d[7:0], 8'h96);
    endtask

    task automatic t_fifo_full;
        logic [15:0] d;
        wr(3'd0, 16'h0); wr(3'd2, 16'h13);
        for (int i = 0; i < 17; i++) wr(3'd5, 16'(i + 8'h20));
        rd(3'd4, d);
        chk("R7 tx full after 16 writes", d[0], 1);
        wr(3'd0, 16'hB);
        idle(5800);
        for (int i = 0; i < 16; i++) begin
            rd(3'd6, d);
            chk("R7 drained byte", d[7:0], 8'(i + 8'h20));
        end
        rd(3'd4, d);
        chk("R7 17th write dropped", d[3], 1);
        rd(3'd6, d);
        rd(3'd4, d);
        chk("R7 empty read leaves queue empty", d[3], 1);
        wr(3'd5, 16'h42);
        idle(400);
        rd(3'd6, d);
        chk("R7 queue intact after empty read", d[7:0], 8'h42);
    endtask

    task automatic t_flush;
        logic [15:0] d;
        wr(3'd0, 16'h0);
        wr(3'd5, 16'h01); wr(3'd5, 16'h02); wr(3'd5, 16'h03);
        wr(3'd2, 16'h11);
        rd(3'd4, d);
        chk("R8 tx queue emptied", d[1], 1);
        rd(3'd2, d);
        chk("R8 reset bits read as zero", d, 16'h10);
        wr(3'd0, 16'hB); wr(3'd5, 16'h5E);
        idle(400);
        rd(3'd4, d);
        chk("R8 rx holds byte before reset", d[3], 0);
        wr(3'd2, 16'h12);
        rd(3'd4, d);
        chk("R8 rx queue emptied", d[3], 1);
    endtask

    task automatic t_rx_irq;
        logic [15:0] d;
        wr(3'd0, 16'h2); wr(3'd2, 16'h10); wr(3'd3, 16'h2);
        ser_send(8'h11, 1'b1);
        chk("R9 level 1 raises rx_irq", rx_irq, 1);
        rd(3'd6, d);
        idle(2);
        chk("R9 rx_irq clears below level", rx_irq, 0);
        wr(3'd2, 16'h30);
        ser_send(8'h21, 1'b1); ser_send(8'h22, 1'b1);
        chk("R9 two bytes below level 3", rx_irq, 0);
        ser_send(8'h23, 1'b1);
        chk("R9 third byte reaches level 3", rx_irq, 1);
        wr(3'd3, 16'h0);
        chk("R13 rx_irq gated off", rx_irq, 0);
        wr(3'd3, 16'h2);
        idle(5);
        chk("R9 enable at level stays quiet", rx_irq, 0);
        wr(3'd2, 16'h12); wr(3'd3, 16'h0);
    endtask

    task automatic t_tx_irq;
        wr(3'd0, 16'h0); wr(3'd2, 16'h11); wr(3'd3, 16'h1);
        idle(5);
        chk("R10 enable while empty stays quiet", tx_irq, 0);
        for (int i = 0; i < 10; i++) wr(3'd5, 16'(i));
        chk("R10 ten queued, no irq", tx_irq, 0);
        wr(3'd0, 16'h1);
        idle(100);
        chk("R10 nine queued, no irq", tx_irq, 0);
        idle(400);
        chk("R10 fill dropped to half", tx_irq, 1);
        wr(3'd3, 16'h0);
        chk("R13 tx_irq gated off", tx_irq, 0);
        wr(3'd2, 16'h11); wr(3'd0, 16'h0);
        idle(400);
    endtask

    task automatic t_bad_stop;
        logic [15:0] d;
        wr(3'd0, 16'h2);
        ser_send(8'h5A, 1'b0);
        rd(3'd4, d);
        chk("R12 low stop bit discarded", d[3], 1);
        ser_send(8'hC3, 1'b1);
        rd(3'd6, d);
        chk("R12 mid-bit sampled byte", d[7:0], 8'hC3);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_nco();
        t_frame();
        t_enable();
        t_flow();
        t_loopback();
        t_fifo_full();
        t_flush();
        t_rx_irq();
        t_tx_irq();
        t_bad_stop();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++; n_fail++;
            $display("FAIL watchdog R1-wide run actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule